// File: doc/BRIEF.md
# Bus-Master Test Function Controller

This block is a register-driven self-test engine for an endpoint-style device. A host sets up a handful of words through a simple register write/read port: a scratch word, buffer addresses, a transfer length, a checksum and an interrupt selection. It then writes a command word. A sequencer carries out the command over a single-outstanding, word-wide memory master port. It can pull a buffer from host memory and check it, push a generated buffer into host memory, or copy one host buffer to another. It records the outcome in a status word and finally requests an interrupt of the selected kind and vector as a one-cycle strobe.

The link layer, message-signalled interrupt formatting and configuration space sit outside the block. The interrupt leaves as `irq_req` with `irq_kind` and `irq_vec` beside it. Lengths count in memory words. Word `i` of a buffer lives at byte address `base + i*(DW/8)`.

Top module: `bm_test_engine`

## Requirements
- R1: Registers sit at word offsets of `reg_addr`: 0 scratch, 1 command, 2 status (read-only), 3 source address, 4 destination address, 5 length in words, 6 checksum, 7 interrupt kind, 8 interrupt vector. The scratch word reads back whatever was last written to it. Reading the command offset returns 0.
- R2: Command bits are 0/1/2 raise interrupt, 3 read, 4 write, 5 copy. When several bits are set, the lowest set bit alone is acted on. A raise command moves no data.
- R3: A command write accepted while idle clears the status word and starts the sequencer (`busy` high). A command write made while `busy` is high, including during the finishing cycle, is ignored.
- R4: Read fetches `length` words from the source buffer and XORs them together. Status bit 0 is set if the result equals the checksum register, bit 1 otherwise. Success and fail bits of one operation are never set together.
- R5: Write stores the value `i` into word `i` of the destination buffer. It then sets status bit 2 and loads the XOR of the words written into the checksum register.
- R6: Copy moves each source word to the same word of the destination buffer. It then sets status bit 4 and loads the XOR of the moved words into the checksum register.
- R7: An address that is zero or not a multiple of DW/8 is invalid. Status bit 7 marks the source and bit 8 the destination, when the command uses that address. The operation's fail bit is set (1 read, 3 write, 5 copy) and no memory access is made.
- R8: A length of zero completes without any memory access and sets the operation's success bit.
- R9: At the end of every accepted command, `irq_req` is high for exactly one cycle. It carries the kind (0 legacy, 1 MSI, 2 MSI-X) and the vector from their registers, and status bit 6 is set. This happens only if kind 0 has vector 0, kind 1 has vector 1..32, or kind 2 has vector 1..2048. Otherwise no strobe occurs and bit 6 stays clear.
- R10: `mem_req` stays high with `mem_addr`, `mem_we` and `mem_wdata` unchanged until `mem_ack`. A cycle with both high completes one word, and read data is taken from `mem_rdata` in that cycle.
- R11: After reset all registers and the status word are 0, and `busy`, `mem_req` and `irq_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access completes this cycle |
| irq_req | output | 1 | One-cycle interrupt request |
| irq_kind | output | 2 | Interrupt kind of the request |
| irq_vec | output | 12 | Interrupt vector of the request |
| busy | output | 1 | Sequencer is running a command |

## Verification
Two functions can meet in one cycle: the host writing a new command, and the sequencer finishing the previous one, which is the cycle in which it raises its interrupt and records status. The bench waits for the `irq_req` strobe and drives a command write into that same cycle. It then requires that the status word holds only the first command's result, that `busy` stays low and that no memory access follows. A second collision is a command write issued mid-transfer. That one is judged by the destination contents, the access count and the status word.

// File: rtl/bm_test_engine.sv
module bm_test_engine #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [3:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack,
  output logic          irq_req,
  output logic [1:0]    irq_kind,
  output logic [11:0]   irq_vec,
  output logic          busy
);
  localparam int LSB = $clog2(DW / 8);
  localparam logic [3:0] O_SCR = 4'd0, O_CMD = 4'd1, O_STS = 4'd2, O_SRC = 4'd3,
                         O_DST = 4'd4, O_LEN = 4'd5, O_SUM = 4'd6, O_KND = 4'd7, O_VEC = 4'd8;
  typedef enum logic [1:0] {S_IDLE, S_XFER, S_FIN} st_t;
  typedef enum logic [1:0] {OP_IRQ, OP_RD, OP_WR, OP_CP} op_t;

  st_t st;
  op_t op, op_n;
  logic [DW-1:0] scr, src, dst, len, sum, knd, vec, cnt, acc, hold;
  logic [8:0] sts;
  logic ph, skip;

  wire cmd_wr = reg_wr && reg_addr == O_CMD && |reg_wdata[5:0];
  wire src_ok = src != '0 && src[LSB-1:0] == '0;
  wire dst_ok = dst != '0 && dst[LSB-1:0] == '0;
  wire irq_ok = (knd == 0 && vec == 0) ||
                (knd == 1 && vec >= 1 && vec <= 32) ||
                (knd == 2 && vec >= 1 && vec <= 2048);
  wire to_dst = op == OP_WR || (op == OP_CP && ph);

  always_comb begin
    if (|reg_wdata[2:0]) op_n = OP_IRQ;
    else if (reg_wdata[3]) op_n = OP_RD;
    else if (reg_wdata[4]) op_n = OP_WR;
    else op_n = OP_CP;
  end

  wire bad_s = (op_n == OP_RD || op_n == OP_CP) && !src_ok;
  wire bad_d = (op_n == OP_WR || op_n == OP_CP) && !dst_ok;
  wire [3:0] ok_bit = {op_n, 1'b0} - 4'd2;

  assign busy      = st != S_IDLE;
  assign mem_req   = st == S_XFER;
  assign mem_we    = mem_req && to_dst;
  assign mem_addr  = (to_dst ? dst[AW-1:0] : src[AW-1:0]) + (AW'(cnt) << LSB);
  assign mem_wdata = op == OP_WR ? cnt : hold;
  assign irq_req   = st == S_FIN && irq_ok;
  assign irq_kind  = knd[1:0];
  assign irq_vec   = vec[11:0];

  always_comb begin
    case (reg_addr)
      O_SCR: reg_rdata = scr;
      O_STS: reg_rdata = DW'(sts);
      O_SRC: reg_rdata = src;
      O_DST: reg_rdata = dst;
      O_LEN: reg_rdata = len;
      O_SUM: reg_rdata = sum;
      O_KND: reg_rdata = knd;
      O_VEC: reg_rdata = vec;
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; op <= OP_IRQ; sts <= '0; ph <= 1'b0; skip <= 1'b0;
      scr <= '0; src <= '0; dst <= '0; len <= '0; sum <= '0; knd <= '0; vec <= '0;
      cnt <= '0; acc <= '0; hold <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          O_SCR: scr <= reg_wdata;
          O_SRC: src <= reg_wdata;
          O_DST: dst <= reg_wdata;
          O_LEN: len <= reg_wdata;
          O_SUM: sum <= reg_wdata;
          O_KND: knd <= reg_wdata;
          O_VEC: vec <= reg_wdata;
          default: ;
        endcase
      end
      case (st)
        S_IDLE: if (cmd_wr) begin
          op <= op_n; cnt <= '0; acc <= '0; ph <= 1'b0; skip <= 1'b1;
          sts <= '0;
          if (op_n == OP_IRQ) st <= S_FIN;
          else if (bad_s || bad_d) begin
            sts[7] <= bad_s; sts[8] <= bad_d; sts[ok_bit + 4'd1] <= 1'b1;
            st <= S_FIN;
          end else if (len == '0) begin
            sts[ok_bit] <= 1'b1;
            st <= S_FIN;
          end else begin
            skip <= 1'b0;
            st <= S_XFER;
          end
        end
        S_XFER: if (mem_ack) begin
          if (op == OP_CP && !ph) begin
            hold <= mem_rdata; acc <= acc ^ mem_rdata; ph <= 1'b1;
          end else begin
            if (op == OP_RD) acc <= acc ^ mem_rdata;
            if (op == OP_WR) acc <= acc ^ cnt;
            ph <= 1'b0;
            cnt <= cnt + 1'b1;
            if (cnt == len - 1'b1) st <= S_FIN;
          end
        end
        S_FIN: begin
          if (!skip) begin
            if (op == OP_RD) sts[(acc == sum) ? 0 : 1] <= 1'b1;
            else begin
              sts[op == OP_WR ? 2 : 4] <= 1'b1;
              sum <= acc;
            end
          end
          if (irq_ok) sts[6] <= 1'b1;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  assert_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[LSB-1:0] == '0);
  assert_irq_logged_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> sts[6]);
  assert_irq_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> !irq_req);
  assert_one_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(sts[0] && sts[1]) && !(sts[2] && sts[3]) && !(sts[4] && sts[5]));
  assert_busy_ignore_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cmd_wr && !irq_req |=> busy);
endmodule

// File: tb/tb_bm_test_engine.sv
module tb_bm_test_engine;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [3:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic mem_req, mem_we, mem_ack = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
  logic irq_req, busy;
  logic [1:0] irq_kind;
  logic [11:0] irq_vec;
  int checks = 0, errors = 0, accesses = 0, writes = 0, irqs = 0, hs_bad = 0;
  logic [1:0] last_kind;
  logic [11:0] last_vec;
  logic [31:0] mem [0:255];
  logic pr_req, pr_ack;
  logic [31:0] pr_addr;

  always #4 clk = ~clk;

  bm_test_engine dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .irq_req(irq_req), .irq_kind(irq_kind), .irq_vec(irq_vec), .busy(busy));

  always @(posedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) mem_rdata <= mem[mem_addr[9:2]];
      if (mem_req && mem_ack) begin
        accesses++;
        if (mem_we) begin mem[mem_addr[9:2]] <= mem_wdata; writes++; end
      end
    end
  end

  always @(negedge clk) begin
    if (irq_req) begin irqs++; last_kind = irq_kind; last_vec = irq_vec; end
    if (rst_n && pr_req && !pr_ack && (!mem_req || mem_addr != pr_addr)) hs_bad++;
    pr_req = mem_req; pr_ack = mem_ack; pr_addr = mem_addr;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while (busy && n < 5000) begin @(negedge clk); n++; end
    if (busy) chk("watchdog", 1, 0);
  endtask

  task automatic run(input logic [31:0] c);
    wr(1, c); wait_idle();
  endtask

  task automatic setup(input logic [31:0] s, input logic [31:0] d, input logic [31:0] l,
                       input logic [31:0] k, input logic [31:0] v);
    wr(3, s); wr(4, d); wr(5, l); wr(7, k); wr(8, v);
  endtask

  task automatic t_reset();
    logic [31:0] r;
    rd(2, r); chk("R11 status", r, 0);
    rd(0, r); chk("R11 scratch", r, 0);
    chk("R11 busy/req/irq", {busy, mem_req, irq_req}, 0);
  endtask

  task automatic t_scratch();
    logic [31:0] r;
    wr(0, 32'hA5C3_0F96); rd(0, r); chk("R1 scratch", r, 32'hA5C3_0F96);
    wr(0, 32'h1234_5678); rd(0, r); chk("R1 scratch 2", r, 32'h1234_5678);
    rd(1, r); chk("R1 command reads 0", r, 0);
  endtask

  task automatic t_write();
    logic [31:0] r; int i0 = irqs;
    setup(0, 32'h100, 5, 1, 5); run(32'h10);
    for (int i = 0; i < 5; i++) chk("R5 data", mem[64+i], i);
    rd(2, r); chk("R5 status", r, 32'h44);
    rd(6, r); chk("R5 checksum", r, 4);
    chk("R9 irq count", irqs - i0, 1);
    chk("R9 kind/vec", {last_kind, last_vec}, {2'd1, 12'd5});
  endtask

  task automatic t_read();
    logic [31:0] r; int a0;
    for (int i = 0; i < 4; i++) mem[16+i] = 32'h1111_0000 * (i + 1) + i;
    setup(32'h40, 0, 4, 0, 0);
    wr(6, mem[16] ^ mem[17] ^ mem[18] ^ mem[19]);
    a0 = accesses; run(32'h08);
    rd(2, r); chk("R4 read ok", r, 32'h41);
    chk("R4 accesses", accesses - a0, 4);
    wr(6, 32'hDEAD); run(32'h08);
    rd(2, r); chk("R4 read mismatch", r, 32'h42);
  endtask

  task automatic t_copy();
    logic [31:0] r;
    setup(32'h40, 32'h200, 4, 2, 7); run(32'h20);
    for (int i = 0; i < 4; i++) chk("R6 data", mem[128+i], mem[16+i]);
    rd(2, r); chk("R6 status", r, 32'h50);
    rd(6, r); chk("R6 checksum", r, mem[16] ^ mem[17] ^ mem[18] ^ mem[19]);
  endtask

  task automatic t_invalid();
    logic [31:0] r; int a0 = accesses;
    setup(32'h42, 32'h200, 4, 0, 0); run(32'h08);
    rd(2, r); chk("R7 unaligned src", r, 32'hC2);
    setup(32'h40, 0, 4, 0, 0); run(32'h20);
    rd(2, r); chk("R7 zero dst copy", r, 32'h160);
    chk("R7 no access", accesses - a0, 0);
  endtask

  task automatic t_empty();
    logic [31:0] r; int a0 = accesses;
    setup(32'h40, 32'h300, 0, 0, 0); run(32'h10);
    rd(2, r); chk("R8 status / R3 cleared", r, 32'h44);
    chk("R8 no access", accesses - a0, 0);
  endtask

  task automatic t_irq_range();
    logic [31:0] r; int i0;
    setup(32'h40, 32'h300, 0, 2, 2048); i0 = irqs; run(32'h01);
    rd(2, r); chk("R9 msix 2048", r, 32'h40);
    chk("R9 msix kind", {irqs - i0, 30'(last_kind)}, {32'd1, 30'd2});
    i0 = irqs;
    wr(8, 2049); run(32'h04); rd(2, r); chk("R9 msix 2049", r, 0);
    wr(7, 1); wr(8, 33); run(32'h02); rd(2, r); chk("R9 msi 33", r, 0);
    wr(7, 3); wr(8, 1); run(32'h01); rd(2, r); chk("R9 kind 3", r, 0);
    wr(7, 0); wr(8, 1); run(32'h01); rd(2, r); chk("R9 legacy vec 1", r, 0);
    chk("R9 no strobes", irqs - i0, 0);
  endtask

  task automatic t_priority();
    logic [31:0] r; int a0, w0;
    setup(32'h40, 32'h300, 4, 0, 0);
    wr(6, mem[16] ^ mem[17] ^ mem[18] ^ mem[19]);
    w0 = writes; run(32'h18);
    rd(2, r); chk("R2 read beats write", r, 32'h41);
    chk("R2 no writes", writes - w0, 0);
    a0 = accesses; run(32'h29);
    rd(2, r); chk("R2 raise beats read", r, 32'h40);
    chk("R2 raise no access", accesses - a0, 0);
  endtask

  task automatic t_busy();
    logic [31:0] r; int a0, w0;
    for (int i = 0; i < 8; i++) mem[192+i] = 32'hFFFF;
    setup(32'h40, 32'h300, 8, 0, 0);
    w0 = writes;
    wr(1, 32'h10);
    wr(1, 32'h20);
    wait_idle();
    chk("R3 mid-run writes", writes - w0, 8);
    for (int i = 0; i < 8; i++) chk("R3 dst data", mem[192+i], i);
    rd(2, r); chk("R3 status kept", r, 32'h44);
    wr(5, 2);
    @(negedge clk); reg_wr = 1; reg_addr = 1; reg_wdata = 32'h10; @(negedge clk); reg_wr = 0;
    while (!irq_req) @(negedge clk);
    a0 = accesses;
    reg_wr = 1; reg_addr = 1; reg_wdata = 32'h20;
    @(negedge clk); reg_wr = 0;
    chk("R3 finish collision busy", busy, 0);
    repeat (4) @(negedge clk);
    chk("R3 finish collision idle", {busy, 31'(accesses - a0)}, 0);
    rd(2, r); chk("R3 finish collision status", r, 32'h44);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_scratch(); t_write(); t_read(); t_copy(); t_invalid();
    t_empty(); t_irq_range(); t_priority(); t_busy();
    chk("R10 handshake held", hs_bad, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule